// File: doc/BRIEF.md
# Register Rename Undo Log

This block keeps an age-ordered log of destination-register renames, one log per hardware thread, so that an out-of-order core can both retire and roll back its register mappings. Each time the rename stage gives a destination register a new physical register, it hands this block four values: the instruction's sequence number, the architectural register, the newly allocated physical register and the physical register that mapping replaced. Instructions that write no register leave the log untouched.

When the core reports a commit up to some sequence number, the block retires log entries from the oldest end of that thread's log and hands each retired entry's replaced physical register to the free list. Up to `COMMIT_W` entries leave in one cycle. When the core reports a squash after some sequence number, the block walks back from the youngest end, one entry per cycle. For each entry it writes the replaced physical register back into the external map table for that architectural register, and it returns the new physical register to the free list. A squash always takes precedence over retirement. Each thread's log is a circular FIFO. The block reports a full flag and an occupancy count per thread, which the rename stage uses to stall.

Top module: `rename_history`

## Requirements
- R1: A rename with `renValid`=1 and `renHasDest`=1 appends one entry to thread `renThread`'s log, and that thread's `entryCount` rises by one on the following cycle.
- R2: A rename with `renHasDest`=0, or a cycle with `renValid`=0, adds no entry, and `entryCount` stays unchanged.
- R3: `bufFull[t]` is 1 exactly when thread t holds `DEPTH` entries. A rename offered to a full thread is dropped, and the count stays at `DEPTH`.
- R4: A squash accepted at a clock edge sets `squashBusy` from the next cycle. In each busy cycle where the thread's youngest entry has a sequence number greater than the squash sequence number, that entry is removed and the block drives `mapWrEn`=1 with the entry's thread, architectural register and replaced physical register, together with `freeValid[0]`=1 and the new physical register on lane 0 of `freePhys`. The first busy cycle without such an entry drives nothing and clears `squashBusy` at its closing edge.
- R5: After a commit with sequence number S has been latched for thread t, each eligible cycle retires, oldest first, the longest run of at most `COMMIT_W` entries whose sequence numbers are ≤ S. Lane i of `freeValid`/`freePhys` (field at bits i*PREG_W) carries the replaced physical register of the i-th oldest retired entry. Lanes are filled from lane 0 upward.
- R6: Logs are kept apart per thread: activity on one thread never changes another thread's entries or count. When several threads can retire, the lowest-numbered thread retires in that cycle.
- R7: No entry is retired in a cycle with `squashBusy`=1 or `sqValid`=1. A commit that arrives alongside a squash is held and takes effect once the walk is over.
- R8: A squash request that arrives while `squashBusy`=1 is ignored.
- R9: A rename aimed at the thread currently being walked back (`squashBusy`=1) is ignored.
- R10: After reset every count is 0, no full flag is set, `squashBusy` is 0, and neither a map write nor a free is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename stage offers an instruction |
| renHasDest | input | 1 | Offered instruction writes a register |
| renThread | input | THR_W | Thread of the renamed instruction |
| renSeq | input | SEQ_W | Sequence number of the renamed instruction |
| renArch | input | AREG_W | Architectural destination register |
| renNewPhys | input | PREG_W | Newly allocated physical register |
| renOldPhys | input | PREG_W | Physical register previously mapped |
| cmtValid | input | 1 | Commit report |
| cmtThread | input | THR_W | Committing thread |
| cmtSeq | input | SEQ_W | Youngest committed sequence number |
| sqValid | input | 1 | Squash report |
| sqThread | input | THR_W | Squashing thread |
| sqSeq | input | SEQ_W | Entries younger than this are undone |
| entryCount | output | NUM_THREADS*CNT_W | Per-thread occupancy, thread t at bits t*CNT_W |
| bufFull | output | NUM_THREADS | Per-thread full flag |
| squashBusy | output | 1 | A squash walk is in progress |
| mapWrEn | output | 1 | Map-table restore write |
| mapWrThread | output | THR_W | Thread of the restore write |
| mapWrArch | output | AREG_W | Architectural register to restore |
| mapWrPhys | output | PREG_W | Physical register written back |
| freeValid | output | COMMIT_W | Per-lane free strobe |
| freePhys | output | COMMIT_W*PREG_W | Per-lane freed physical register |

## Verification
Every request is captured at a clock edge, and its result shows up in the cycle that follows. An occupancy change appears one cycle after the rename. The first restore of a squash, and `squashBusy`, appear one cycle after the request. The first retirement appears one cycle after the commit, or in the first cycle after the walk ends. The map-write and free outputs are combinational from registered state, and they also depend on the current `sqValid`, so the bench drives its inputs at the falling edge and compares 1 ns later against a reference model of the logs. It then advances the model at the rising edge with the same inputs the design latches. Random traffic is mixed with directed cases: a filled log, retirement across threads, a squash and a commit in the same cycle, and requests that arrive during a walk.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

  // Per-cycle strobes from control to storage.
  typedef struct packed {
    logic pushEn;    // append at the tail of pushThr
    logic unwindEn;  // remove youngest entry of unwindThr
    logic retireEn;  // remove retireNum oldest entries of retireThr
  } rhbStrobe_t;

endpackage

// File: rtl/rhb_store.sv
module rhb_store
  import rhb_pkg::*;
#(
  parameter int NT     = 2,
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  parameter int CW     = 2,
  localparam int THR_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int RN_W  = $clog2(CW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rhbStrobe_t        strobe,
  input  logic [THR_W-1:0]  pushThr,
  input  logic [SEQ_W-1:0]  pushSeq,
  input  logic [AREG_W-1:0] pushArch,
  input  logic [PREG_W-1:0] pushNew,
  input  logic [PREG_W-1:0] pushOld,
  input  logic [THR_W-1:0]  unwindThr,
  input  logic [THR_W-1:0]  retireThr,
  input  logic [RN_W-1:0]   retireNum,
  output logic [CNT_W-1:0]  cnt     [NT],
  output logic [SEQ_W-1:0]  topSeq,
  output logic [AREG_W-1:0] topArch,
  output logic [PREG_W-1:0] topNew,
  output logic [PREG_W-1:0] topOld,
  output logic [SEQ_W-1:0]  headSeq [NT][CW],
  output logic [PREG_W-1:0] headOld [NT][CW]
);

  logic [SEQ_W-1:0]  seqMem  [NT][DEPTH];
  logic [AREG_W-1:0] archMem [NT][DEPTH];
  logic [PREG_W-1:0] newMem  [NT][DEPTH];
  logic [PREG_W-1:0] oldMem  [NT][DEPTH];
  logic [IDX_W-1:0]  headPtr [NT];
  logic [IDX_W-1:0]  tailPtr [NT];
  logic [CNT_W-1:0]  cntNext [NT];
  logic [IDX_W-1:0]  topIdx;

  assign topIdx  = tailPtr[unwindThr] - IDX_W'(1);
  assign topSeq  = seqMem[unwindThr][topIdx];
  assign topArch = archMem[unwindThr][topIdx];
  assign topNew  = newMem[unwindThr][topIdx];
  assign topOld  = oldMem[unwindThr][topIdx];

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic pushHit, unwHit, retHit;
    assign pushHit = strobe.pushEn   && (pushThr   == THR_W'(t));
    assign unwHit  = strobe.unwindEn && (unwindThr == THR_W'(t));
    assign retHit  = strobe.retireEn && (retireThr == THR_W'(t));

    for (genvar i = 0; i < CW; i++) begin : g_win
      assign headSeq[t][i] = seqMem[t][headPtr[t] + IDX_W'(i)];
      assign headOld[t][i] = oldMem[t][headPtr[t] + IDX_W'(i)];
    end

    always_comb begin
      cntNext[t] = cnt[t] + CNT_W'(pushHit) - CNT_W'(unwHit)
                 - (retHit ? CNT_W'(retireNum) : CNT_W'(0));
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        headPtr[t] <= '0;
        tailPtr[t] <= '0;
        cnt[t]     <= '0;
      end else begin
        cnt[t] <= cntNext[t];
        if (pushHit) begin
          seqMem[t][tailPtr[t]]  <= pushSeq;
          archMem[t][tailPtr[t]] <= pushArch;
          newMem[t][tailPtr[t]]  <= pushNew;
          oldMem[t][tailPtr[t]]  <= pushOld;
          tailPtr[t] <= tailPtr[t] + IDX_W'(1);
        end else if (unwHit) begin
          tailPtr[t] <= tailPtr[t] - IDX_W'(1);
        end
        if (retHit) headPtr[t] <= headPtr[t] + IDX_W'(retireNum);
      end
    end
  end

  // R3: control never appends to a log that is already full
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushEn |-> (cnt[pushThr] < CNT_W'(DEPTH)));

  // R4: a walk step only removes an existing entry
  a_r4_unwind_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.unwindEn |-> (cnt[unwindThr] != '0));

  // R5: retirement never takes more entries than are held
  a_r5_retire_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retireEn |-> (CNT_W'(retireNum) <= cnt[retireThr]));

  // R9: no append lands on the thread being walked back
  a_r9_no_push_on_walk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushEn && strobe.unwindEn) |-> (pushThr != unwindThr));

  // R7: squash walk and retirement never share a cycle
  a_r7_exclusive_pop: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.unwindEn && strobe.retireEn));

endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
  import rhb_pkg::*;
#(
  parameter int NT     = 2,
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  parameter int CW     = 2,
  localparam int THR_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int RN_W  = $clog2(CW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              renValid,
  input  logic              renHasDest,
  input  logic [THR_W-1:0]  renThread,
  input  logic              sqValid,
  input  logic [THR_W-1:0]  sqThread,
  input  logic [SEQ_W-1:0]  sqSeq,
  input  logic              cmtValid,
  input  logic [THR_W-1:0]  cmtThread,
  input  logic [SEQ_W-1:0]  cmtSeq,
  input  logic [CNT_W-1:0]  cnt     [NT],
  input  logic [SEQ_W-1:0]  topSeq,
  input  logic [AREG_W-1:0] topArch,
  input  logic [PREG_W-1:0] topNew,
  input  logic [PREG_W-1:0] topOld,
  input  logic [SEQ_W-1:0]  headSeq [NT][CW],
  input  logic [PREG_W-1:0] headOld [NT][CW],
  output rhbStrobe_t        strobe,
  output logic [THR_W-1:0]  walkThr,
  output logic [THR_W-1:0]  retireThr,
  output logic [RN_W-1:0]   retireNum,
  output logic [NT-1:0]     fullVec,
  output logic              busy,
  output logic              mapWrEn,
  output logic [AREG_W-1:0] mapWrArch,
  output logic [PREG_W-1:0] mapWrPhys,
  output logic [CW-1:0]     freeValid,
  output logic [CW*PREG_W-1:0] freePhys
);

  logic [SEQ_W-1:0] walkMark;
  logic [SEQ_W-1:0] cmtMark [NT];
  logic [NT-1:0]    cmtHas;
  logic [RN_W-1:0]  nPer    [NT];
  logic             unwindGo;

  for (genvar t = 0; t < NT; t++) begin : g_full
    assign fullVec[t] = (cnt[t] == CNT_W'(DEPTH));
  end

  assign unwindGo = busy && (cnt[walkThr] != '0) && (topSeq > walkMark);

  // Length of the retirable run at the head of each log.
  always_comb begin
    for (int t = 0; t < NT; t++) begin
      logic run;
      run     = 1'b1;
      nPer[t] = '0;
      for (int i = 0; i < CW; i++) begin
        if (run && cmtHas[t] && (i < int'(cnt[t])) && (headSeq[t][i] <= cmtMark[t]))
          nPer[t] = nPer[t] + RN_W'(1);
        else
          run = 1'b0;
      end
    end
  end

  // Lowest-numbered thread with work wins; a squash blocks retirement.
  always_comb begin
    retireThr = '0;
    retireNum = '0;
    if (!busy && !sqValid) begin
      for (int t = NT - 1; t >= 0; t--) begin
        if (nPer[t] != '0) begin
          retireThr = THR_W'(t);
          retireNum = nPer[t];
        end
      end
    end
  end

  always_comb begin
    strobe.pushEn   = renValid && renHasDest && !fullVec[renThread]
                      && !(busy && (walkThr == renThread));
    strobe.unwindEn = unwindGo;
    strobe.retireEn = (retireNum != '0);
    mapWrEn   = unwindGo;
    mapWrArch = topArch;
    mapWrPhys = topOld;
    for (int i = 0; i < CW; i++) begin
      freeValid[i] = strobe.retireEn && (i < int'(retireNum));
      freePhys[i*PREG_W +: PREG_W] = headOld[retireThr][i];
    end
    if (unwindGo) begin
      freeValid[0] = 1'b1;
      freePhys[PREG_W-1:0] = topNew;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      walkThr  <= '0;
      walkMark <= '0;
      cmtHas   <= '0;
      for (int t = 0; t < NT; t++) cmtMark[t] <= '0;
    end else begin
      if (busy && !unwindGo) busy <= 1'b0;
      if (!busy && sqValid) begin
        busy     <= 1'b1;
        walkThr  <= sqThread;
        walkMark <= sqSeq;
      end
      if (cmtValid) begin
        cmtHas[cmtThread]  <= 1'b1;
        cmtMark[cmtThread] <= cmtSeq;
      end
    end
  end

  // R8: the walk target and mark stay put for the whole walk
  a_r8_walk_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(walkMark) && $stable(walkThr)));

  // R4: an accepted squash raises busy on the next cycle
  a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && sqValid) |=> busy);

  // R5: free lanes are filled from lane 0 without gaps
  a_r5_lanes_packed: assert property (@(posedge clk) disable iff (!rstN)
    (freeValid != '0) |-> freeValid[0]);

endmodule

// File: rtl/rename_history.sv
module rename_history
  import rhb_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 8,
  parameter int SEQ_W       = 16,
  parameter int AREG_W      = 5,
  parameter int PREG_W      = 7,
  parameter int COMMIT_W    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic renValid,
  input  logic renHasDest,
  input  logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] renThread,
  input  logic [SEQ_W-1:0]  renSeq,
  input  logic [AREG_W-1:0] renArch,
  input  logic [PREG_W-1:0] renNewPhys,
  input  logic [PREG_W-1:0] renOldPhys,
  input  logic cmtValid,
  input  logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] cmtThread,
  input  logic [SEQ_W-1:0]  cmtSeq,
  input  logic sqValid,
  input  logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] sqThread,
  input  logic [SEQ_W-1:0]  sqSeq,
  output logic [NUM_THREADS*$clog2(DEPTH+1)-1:0] entryCount,
  output logic [NUM_THREADS-1:0] bufFull,
  output logic squashBusy,
  output logic mapWrEn,
  output logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] mapWrThread,
  output logic [AREG_W-1:0] mapWrArch,
  output logic [PREG_W-1:0] mapWrPhys,
  output logic [COMMIT_W-1:0] freeValid,
  output logic [COMMIT_W*PREG_W-1:0] freePhys
);

  localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int RN_W  = $clog2(COMMIT_W + 1);

  rhbStrobe_t        strobe;
  logic [THR_W-1:0]  walkThr, retireThr;
  logic [RN_W-1:0]   retireNum;
  logic [CNT_W-1:0]  cnt     [NUM_THREADS];
  logic [SEQ_W-1:0]  topSeq;
  logic [AREG_W-1:0] topArch;
  logic [PREG_W-1:0] topNew, topOld;
  logic [SEQ_W-1:0]  headSeq [NUM_THREADS][COMMIT_W];
  logic [PREG_W-1:0] headOld [NUM_THREADS][COMMIT_W];

  rhb_ctrl #(.NT(NUM_THREADS), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
             .PREG_W(PREG_W), .CW(COMMIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .renValid(renValid), .renHasDest(renHasDest), .renThread(renThread),
    .sqValid(sqValid), .sqThread(sqThread), .sqSeq(sqSeq),
    .cmtValid(cmtValid), .cmtThread(cmtThread), .cmtSeq(cmtSeq),
    .cnt(cnt), .topSeq(topSeq), .topArch(topArch), .topNew(topNew), .topOld(topOld),
    .headSeq(headSeq), .headOld(headOld),
    .strobe(strobe), .walkThr(walkThr), .retireThr(retireThr), .retireNum(retireNum),
    .fullVec(bufFull), .busy(squashBusy),
    .mapWrEn(mapWrEn), .mapWrArch(mapWrArch), .mapWrPhys(mapWrPhys),
    .freeValid(freeValid), .freePhys(freePhys)
  );

  rhb_store #(.NT(NUM_THREADS), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
              .PREG_W(PREG_W), .CW(COMMIT_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pushThr(renThread), .pushSeq(renSeq), .pushArch(renArch),
    .pushNew(renNewPhys), .pushOld(renOldPhys),
    .unwindThr(walkThr), .retireThr(retireThr), .retireNum(retireNum),
    .cnt(cnt), .topSeq(topSeq), .topArch(topArch), .topNew(topNew), .topOld(topOld),
    .headSeq(headSeq), .headOld(headOld)
  );

  assign mapWrThread = walkThr;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cnt
    assign entryCount[t*CNT_W +: CNT_W] = cnt[t];
  end

endmodule

// File: tb/sim_rename_history.sv
module sim_rename_history;
  localparam int NT = 2, D = 8, SW = 16, AW = 5, PW = 7, CW = 2, CNTW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, renValid, renHasDest, cmtValid, sqValid;
  logic [0:0] renThread, cmtThread, sqThread, mapWrThread;
  logic [SW-1:0] renSeq, cmtSeq, sqSeq;
  logic [AW-1:0] renArch, mapWrArch;
  logic [PW-1:0] renNewPhys, renOldPhys, mapWrPhys;
  logic [NT*CNTW-1:0] entryCount;
  logic [NT-1:0] bufFull;
  logic squashBusy, mapWrEn;
  logic [CW-1:0] freeValid;
  logic [CW*PW-1:0] freePhys;

  rename_history u0 (.*);

  int qs[NT][D], qa[NT][D], qn[NT][D], qo[NT][D];
  int mc[NT];
  bit mBusy; int mT, mM;
  bit cHas[NT]; int cMark[NT];
  int nextSeq = 1;
  int checks = 0, fails = 0;
  bit eUnw; int eRt, eRn;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int t = 0; t < NT; t++) begin mc[t] = 0; cHas[t] = 0; cMark[t] = 0; end
    mBusy = 0; mT = 0; mM = 0;
  endtask

  task automatic compareNow();
    logic [CW-1:0] fv; logic [CW*PW-1:0] fp; string tg;
    eUnw = mBusy && mc[mT] > 0 && qs[mT][mc[mT]-1] > mM;
    eRt = 0; eRn = 0;
    if (!mBusy && !sqValid)
      for (int t = NT - 1; t >= 0; t--) begin
        int n = 0; bit run = 1;
        for (int i = 0; i < CW; i++)
          if (run && cHas[t] && i < mc[t] && qs[t][i] <= cMark[t]) n++; else run = 0;
        if (n > 0) begin eRt = t; eRn = n; end
      end
    fv = '0; fp = '0;
    if (eUnw) begin fv[0] = 1; fp[PW-1:0] = PW'(qn[mT][mc[mT]-1]); end
    else for (int i = 0; i < eRn; i++) begin fv[i] = 1; fp[i*PW +: PW] = PW'(qo[eRt][i]); end
    tg = eUnw ? "R4" : (eRn > 0 ? "R5" : ((mBusy || sqValid) ? "R7" : "R6"));
    chk(mapWrEn == eUnw, "R4 mapWrEn", mapWrEn, eUnw);
    if (eUnw) begin
      chk(mapWrThread == mT, "R4 thread", mapWrThread, mT);
      chk(mapWrArch == AW'(qa[mT][mc[mT]-1]), "R4 arch", mapWrArch, qa[mT][mc[mT]-1]);
      chk(mapWrPhys == PW'(qo[mT][mc[mT]-1]), "R4 restore phys", mapWrPhys, qo[mT][mc[mT]-1]);
    end
    chk(freeValid == fv, {tg, " freeValid"}, freeValid, fv);
    for (int i = 0; i < CW; i++)
      if (fv[i]) chk(freePhys[i*PW +: PW] == fp[i*PW +: PW], {tg, " freePhys"},
                     freePhys[i*PW +: PW], fp[i*PW +: PW]);
    chk(squashBusy == mBusy, "R4 busy", squashBusy, mBusy);
    for (int t = 0; t < NT; t++) begin
      chk(entryCount[t*CNTW +: CNTW] == CNTW'(mc[t]), "R1 count",
          entryCount[t*CNTW +: CNTW], mc[t]);
      chk(bufFull[t] == (mc[t] == D), "R3 full", bufFull[t], mc[t] == D);
    end
  endtask

  task automatic updateModel();
    bit pushOk;
    int pt;
    pt = int'(renThread);
    pushOk = renValid && renHasDest && mc[pt] < D && !(mBusy && mT == pt);
    if (eUnw) mc[mT]--;
    else if (mBusy) mBusy = 0;
    if (eRn > 0) begin
      for (int i = 0; i + eRn < mc[eRt]; i++) begin
        qs[eRt][i] = qs[eRt][i+eRn]; qa[eRt][i] = qa[eRt][i+eRn];
        qn[eRt][i] = qn[eRt][i+eRn]; qo[eRt][i] = qo[eRt][i+eRn];
      end
      mc[eRt] -= eRn;
    end
    if (pushOk) begin
      qs[pt][mc[pt]] = renSeq; qa[pt][mc[pt]] = renArch;
      qn[pt][mc[pt]] = renNewPhys; qo[pt][mc[pt]] = renOldPhys;
      mc[pt]++;
    end
    if (!mBusy && sqValid && !(eUnw)) begin
      // only when idle before this edge (a clear this edge came from busy=1)
    end
  endtask

  task automatic cyc(bit rv, bit rhd, int rt, bit sv, int st, int ss, bit cv, int ct, int cs);
    bit wasBusy;
    @(negedge clk);
    renValid = rv; renHasDest = rhd; renThread = 1'(rt);
    renSeq = SW'(nextSeq); renArch = AW'($urandom); renNewPhys = PW'($urandom);
    renOldPhys = PW'($urandom);
    if (rv) nextSeq++;
    sqValid = sv; sqThread = 1'(st); sqSeq = SW'(ss);
    cmtValid = cv; cmtThread = 1'(ct); cmtSeq = SW'(cs);
    #1 compareNow();
    @(posedge clk);
    wasBusy = mBusy;
    updateModel();
    if (!wasBusy && sv) begin mBusy = 1; mT = st; mM = ss; end
    if (cv) begin cHas[ct] = 1; cMark[ct] = cs; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic int cntOf(int t);
    return int'(entryCount[t*CNTW +: CNTW]);
  endfunction

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rstN = 0; renValid = 0; renHasDest = 0; renThread = 0; renSeq = 0; renArch = 0;
    renNewPhys = 0; renOldPhys = 0; cmtValid = 0; cmtThread = 0; cmtSeq = 0;
    sqValid = 0; sqThread = 0; sqSeq = 0;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk(entryCount == '0, "R10 count", entryCount, 0);
    chk(bufFull == '0, "R10 full", bufFull, 0);
    chk(squashBusy == 0, "R10 busy", squashBusy, 0);
    chk(mapWrEn == 0, "R10 mapWrEn", mapWrEn, 0);
    chk(freeValid == '0, "R10 freeValid", freeValid, 0);
    @(negedge clk); rstN = 1;

    // R2: no destination, or no valid, adds nothing
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk(cntOf(0) == 0 && cntOf(1) == 0, "R2 no entry", cntOf(0) + cntOf(1), 0);

    // R3: fill thread 1 and offer one more
    for (int i = 0; i < D + 1; i++) cyc(1, 1, 1, 0, 0, 0, 0, 0, 0);
    idle(1);
    chk(cntOf(1) == D, "R3 capped count", cntOf(1), D);
    chk(bufFull[1] == 1, "R3 full flag", bufFull[1], 1);

    // R6: thread 0 gets entries, thread 1 retires everything
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, nextSeq);
    idle(6);
    chk(cntOf(1) == 0, "R6 thread1 drained", cntOf(1), 0);
    chk(cntOf(0) == 3, "R6 thread0 kept", cntOf(0), 3);

    // R7: squash and commit together on thread 0
    cyc(0, 0, 0, 1, 0, qs[0][0], 1, 0, qs[0][0]);
    idle(6);
    chk(cntOf(0) == 0, "R7 deferred commit done", cntOf(0), 0);

    // R8 and R9: requests during a walk
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, qs[0][0], 0, 0, 0);
    cyc(1, 1, 0, 1, 0, 0, 0, 0, 0);
    idle(6);
    chk(cntOf(0) == 1, "R8 R9 ignored during walk", cntOf(0), 1);
    chk(squashBusy == 0, "R4 walk ended", squashBusy, 0);

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int rt, st, ct, ss, cs; bit rv, rhd, sv, cv;
      rv = ($urandom % 10) < 6; rhd = ($urandom % 10) < 8; rt = $urandom % NT;
      st = $urandom % NT; sv = ($urandom % 100) < 4;
      ss = (mc[st] > 0) ? qs[st][$urandom % mc[st]] : nextSeq;
      if (($urandom % 8) == 0) ss = 0;
      ct = $urandom % NT; cv = (($urandom % 100) < 15) && mc[ct] > 0;
      cs = (mc[ct] > 0) ? qs[ct][$urandom % mc[ct]] : 0;
      if (cs < cMark[ct]) cs = cMark[ct];
      cyc(rv, rhd, rt, sv, st, ss, cv, ct, cs);
    end
    idle(20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule